// File: doc/BRIEF.md
# Narrow Port Width Adapter

This block joins a 32-bit memory-mapped master to a small peripheral with an 8-bit data path, 5 address bits and active-low chip-select, read and write strobes. A master access is held off with a wait-request while the adapter runs one or more single-cycle strobes on the peripheral side. When the last strobe is done, the adapter releases the master. Read data is returned in the same cycle that the wait-request drops.

A mode pin picks one of two mappings. In byte-lane mode the adapter sizes the bus itself. A 32-bit read becomes four byte reads of consecutive peripheral locations. A write touches only the lanes whose byte enable is set. In register mode every word-aligned master address selects exactly one peripheral register. The two low master address bits are dropped, and a single strobe is issued, so neighbouring registers are never disturbed. A peripheral register narrower than the master word can then be read or written with one access.

Top module: `narrow_port_adapter`

## Requirements
- R1: After reset and whenever no access is in progress, s_cs_n, s_rd_n and s_wr_n are high, m_waitreq is low and m_rdata is zero until the first read completes.
- R2: In byte-lane mode (reg_mode = 0), a master read issues four slave reads at addresses {m_addr[4:2], 2'b00} + 0, 1, 2, 3 in ascending order. The byte from offset k lands in m_rdata[8k+7:8k].
- R3: In byte-lane mode, a master write issues one slave write per set bit of m_be, lowest lane first. Lane k writes m_wdata[8k+7:8k] to offset k. Lanes with a clear enable are skipped, and an all-zero m_be issues no slave strobe at all.
- R4: In register mode (reg_mode = 1), a master read issues exactly one slave read at address m_addr[6:2]. m_rdata[7:0] carries the byte and m_rdata[31:8] is zero.
- R5: In register mode, a master write issues exactly one slave write of m_wdata[7:0] to address m_addr[6:2], whatever the value of m_be.
- R6: Each slave strobe lasts one cycle with s_cs_n low and exactly one of s_rd_n and s_wr_n low. Every strobe is followed by at least one cycle with all three strobes high.
- R7: m_waitreq is high from the first cycle of a request until the cycle after the last slave strobe. In that cycle it is low and m_rdata holds the assembled read word. An access with no strobes completes in the second cycle.
- R8: reg_mode is taken only in the first cycle of an access. A change during an access leaves its strobe count and addressing unchanged.
- R9: In byte-lane mode, m_addr[1:0] has no effect on the slave addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_mode | input | 1 | 1 = register mode, 0 = byte-lane sizing mode |
| m_read | input | 1 | Master read request, held until m_waitreq is low |
| m_write | input | 1 | Master write request, held until m_waitreq is low |
| m_addr | input | 7 | Master byte address |
| m_wdata | input | 32 | Master write data |
| m_be | input | 4 | Master byte enables |
| m_waitreq | output | 1 | Master stall |
| m_rdata | output | 32 | Master read data |
| s_cs_n | output | 1 | Slave chip select, active low |
| s_rd_n | output | 1 | Slave read strobe, active low |
| s_wr_n | output | 1 | Slave write strobe, active low |
| s_addr | output | 5 | Slave register address |
| s_wdata | output | 8 | Slave write data |
| s_rdata | input | 8 | Slave read data, valid during a read strobe |

## Verification
The bench targets sparse byte enables such as 1010 and 0000. A design that ignored them would write stale bytes into unselected lanes, or would hang or strobe when no lane is selected. It flips the mode pin in the middle of an access. A design that looked at the live pin would then switch between four strobes and one, or change its address mapping part way through. It reads register-mode locations whose neighbours hold distinct values. A wrong shift, a missing zero-fill of the upper 24 bits, or a byte packed into the wrong lane then shows up as a wrong address or a wrong read word. Every cycle is compared for the strobe shape and for how long the wait-request is held, so an extra or merged strobe, or a release one cycle early, is reported.

// File: rtl/npa_pkg.sv
package npa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_GAP  = 2'd2,
        ST_DONE = 2'd3
    } npa_state_e;
endpackage

// File: rtl/npa_lane_pick.sv
// Lowest set lane of a mask: gives ascending lane order.
module npa_lane_pick #(
    parameter int LANES = 4,
    parameter int LW    = $clog2(LANES)
) (
    input  logic [LANES-1:0] mask,
    output logic             any,
    output logic [LW-1:0]    idx
);
    always_comb begin
        any = |mask;
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (mask[i]) idx = LW'(i);
        end
    end
endmodule

// File: rtl/npa_rd_pack.sv
// Inserts one returned slave byte into its lane of the read word.
module npa_rd_pack #(
    parameter int SLV_DW = 8,
    parameter int LANES  = 4,
    parameter int LW     = $clog2(LANES)
) (
    input  logic [SLV_DW*LANES-1:0] word_in,
    input  logic [LW-1:0]           lane,
    input  logic [SLV_DW-1:0]       byte_in,
    output logic [SLV_DW*LANES-1:0] word_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_out[g*SLV_DW +: SLV_DW] =
            (lane == LW'(g)) ? byte_in : word_in[g*SLV_DW +: SLV_DW];
    end
endmodule

// File: rtl/narrow_port_adapter.sv
module narrow_port_adapter #(
    parameter int MST_DW = 32,
    parameter int SLV_DW = 8,
    parameter int SLV_AW = 5,
    parameter int LANES  = MST_DW / SLV_DW,
    parameter int LW     = $clog2(LANES),
    parameter int MST_AW = SLV_AW + LW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_mode,
    input  logic              m_read,
    input  logic              m_write,
    input  logic [MST_AW-1:0] m_addr,
    input  logic [MST_DW-1:0] m_wdata,
    input  logic [LANES-1:0]  m_be,
    output logic              m_waitreq,
    output logic [MST_DW-1:0] m_rdata,
    output logic              s_cs_n,
    output logic              s_rd_n,
    output logic              s_wr_n,
    output logic [SLV_AW-1:0] s_addr,
    output logic [SLV_DW-1:0] s_wdata,
    input  logic [SLV_DW-1:0] s_rdata
);
    import npa_pkg::*;

    typedef struct packed {
        npa_state_e        st;
        logic              regm;   // mode frozen for this access
        logic              wr;
        logic [LANES-1:0]  rem;    // lanes still to strobe
        logic [LW-1:0]     lane;
        logic [SLV_AW-1:0] base;
        logic [MST_DW-1:0] wdat;
        logic [MST_DW-1:0] rdat;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [LANES-1:0]  init_mask;
    logic [LANES-1:0]  pick_in;
    logic              pick_any;
    logic [LW-1:0]     pick_idx;
    logic [MST_DW-1:0] packed_word;
    logic [LANES-1:0]  rem_after;

    // Register mode: one lane; read: all lanes; write: enabled lanes.
    assign init_mask = reg_mode ? LANES'(1) : (m_write ? m_be : '1);
    assign pick_in   = (ctx_q.st == ST_IDLE) ? init_mask : ctx_q.rem;
    assign rem_after = ctx_q.rem & ~(LANES'(1) << ctx_q.lane);

    npa_lane_pick #(.LANES(LANES), .LW(LW)) u_pick (
        .mask (pick_in),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    npa_rd_pack #(.SLV_DW(SLV_DW), .LANES(LANES), .LW(LW)) u_pack (
        .word_in  (ctx_q.rdat),
        .lane     (ctx_q.lane),
        .byte_in  (s_rdata),
        .word_out (packed_word)
    );

    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.st)
            ST_IDLE: begin
                if (m_read || m_write) begin
                    ctx_d.regm = reg_mode;
                    ctx_d.wr   = m_write;
                    ctx_d.rem  = init_mask;
                    ctx_d.lane = pick_idx;
                    ctx_d.base = reg_mode ? m_addr[MST_AW-1:LW]
                                          : {m_addr[SLV_AW-1:LW], LW'(0)};
                    ctx_d.wdat = m_wdata;
                    ctx_d.rdat = '0;
                    ctx_d.st   = pick_any ? ST_BEAT : ST_DONE;
                end
            end
            ST_BEAT: begin
                ctx_d.rem = rem_after;
                if (!ctx_q.wr) begin
                    ctx_d.rdat = ctx_q.regm ? MST_DW'(s_rdata) : packed_word;
                end
                ctx_d.st = (rem_after == '0) ? ST_DONE : ST_GAP;
            end
            ST_GAP: begin
                ctx_d.lane = pick_idx;
                ctx_d.st   = ST_BEAT;
            end
            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign s_cs_n    = (ctx_q.st != ST_BEAT);
    assign s_rd_n    = !((ctx_q.st == ST_BEAT) && !ctx_q.wr);
    assign s_wr_n    = !((ctx_q.st == ST_BEAT) && ctx_q.wr);
    assign s_addr    = ctx_q.base | SLV_AW'(ctx_q.lane);
    assign s_wdata   = ctx_q.wdat[ctx_q.lane*SLV_DW +: SLV_DW];
    assign m_waitreq = (m_read || m_write) && (ctx_q.st != ST_DONE);
    assign m_rdata   = ctx_q.rdat;
endmodule

// File: rtl/npa_checker.sv
module npa_checker (
    input logic clk,
    input logic rst_n,
    input logic m_read,
    input logic m_write,
    input logic m_waitreq,
    input logic s_cs_n,
    input logic s_rd_n,
    input logic s_wr_n
);
    // R6: a selected cycle has exactly one direction strobe
    p_one_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !s_cs_n |-> ($countones({s_rd_n, s_wr_n}) == 1));

    // R1, R6: no direction strobe without chip select
    p_quiet_when_unselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_cs_n |-> (s_rd_n && s_wr_n));

    // R6: every strobe lasts one cycle and is followed by an idle cycle
    p_gap_after_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !s_cs_n |=> s_cs_n);

    // R7: the master is stalled while a strobe is out
    p_stall_during_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_cs_n && (m_read || m_write)) |-> m_waitreq);

    // R1: no stall without a request
    p_no_stall_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_read && !m_write) |-> !m_waitreq);
endmodule

bind narrow_port_adapter npa_checker u_npa_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_read    (m_read),
    .m_write   (m_write),
    .m_waitreq (m_waitreq),
    .s_cs_n    (s_cs_n),
    .s_rd_n    (s_rd_n),
    .s_wr_n    (s_wr_n)
);

// File: tb/narrow_port_adapter_test.sv
module narrow_port_adapter_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_mode = 1'b0;
    logic        m_read = 1'b0;
    logic        m_write = 1'b0;
    logic [6:0]  m_addr = '0;
    logic [31:0] m_wdata = '0;
    logic [3:0]  m_be = '0;
    logic        m_waitreq;
    logic [31:0] m_rdata;
    logic        s_cs_n, s_rd_n, s_wr_n;
    logic [4:0]  s_addr;
    logic [7:0]  s_wdata;
    logic [7:0]  s_rdata;

    int compared = 0;
    int mismatched = 0;

    always #(CLK_P/2) clk = ~clk;

    narrow_port_adapter uut (
        .clk(clk), .rst_n(rst_n), .reg_mode(reg_mode),
        .m_read(m_read), .m_write(m_write), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_be(m_be), .m_waitreq(m_waitreq),
        .m_rdata(m_rdata), .s_cs_n(s_cs_n), .s_rd_n(s_rd_n),
        .s_wr_n(s_wr_n), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_rdata(s_rdata)
    );

    // Peripheral model
    logic [7:0] slv_mem [32];
    assign s_rdata = slv_mem[s_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) slv_mem[i] <= 8'(i * 7 + 3);
        end else if (!s_cs_n && !s_wr_n) begin
            slv_mem[s_addr] <= s_wdata;
        end
    end

    // Reference contents kept by the bench from its own expectations
    logic [7:0] ref_mem [32];

    typedef struct {
        bit         cs_n, rd_n, wr_n, wait_exp, chk_rd;
        logic [4:0] addr;
        logic [7:0] wdata;
    } cyc_t;

    task automatic check(input bit ok, input string tag, input string what);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    task automatic run(input bit wr, input bit regm, input logic [6:0] a,
                       input logic [31:0] wd, input logic [3:0] be,
                       input bit flip, input string tag);
        cyc_t        tr[$];
        cyc_t        c;
        int          lanes[$];
        logic [4:0]  base;
        logic [31:0] exp_rd;
        if (regm) begin
            base = a[6:2];
            lanes.push_back(0);
        end else begin
            base = {a[4:2], 2'b00};
            for (int k = 0; k < 4; k++) if (!wr || be[k]) lanes.push_back(k);
        end
        exp_rd = '0;
        if (regm) exp_rd[7:0] = ref_mem[base];
        else for (int k = 0; k < 4; k++) exp_rd[8*k +: 8] = ref_mem[base + 5'(k)];
        c = '{cs_n:1, rd_n:1, wr_n:1, wait_exp:1, chk_rd:0, addr:'0, wdata:'0};
        tr.push_back(c);
        for (int i = 0; i < lanes.size(); i++) begin
            c = '{cs_n:0, rd_n:wr, wr_n:!wr, wait_exp:1, chk_rd:0,
                  addr:base + 5'(lanes[i]),
                  wdata:(regm ? wd[7:0] : wd[8*lanes[i] +: 8])};
            tr.push_back(c);
            if (i < lanes.size() - 1) begin
                c = '{cs_n:1, rd_n:1, wr_n:1, wait_exp:1, chk_rd:0, addr:'0, wdata:'0};
                tr.push_back(c);
            end
        end
        c = '{cs_n:1, rd_n:1, wr_n:1, wait_exp:0, chk_rd:!wr, addr:'0, wdata:'0};
        tr.push_back(c);

        reg_mode = regm; m_read = !wr; m_write = wr;
        m_addr = a; m_wdata = wd; m_be = be;
        foreach (tr[i]) begin
            if (flip && i == 1) reg_mode = !regm;
            #1;
            check(s_cs_n == tr[i].cs_n && s_rd_n == tr[i].rd_n &&
                  s_wr_n == tr[i].wr_n && m_waitreq == tr[i].wait_exp &&
                  (tr[i].cs_n || s_addr == tr[i].addr) &&
                  (tr[i].cs_n || tr[i].wr_n || s_wdata == tr[i].wdata) &&
                  (!tr[i].chk_rd || m_rdata == exp_rd),
                  tag,
                  $sformatf("cycle %0d actual cs%b rd%b wr%b wait%b addr%0d wd%h rd%h expected cs%b rd%b wr%b wait%b addr%0d wd%h rd%h",
                            i, s_cs_n, s_rd_n, s_wr_n, m_waitreq, s_addr, s_wdata, m_rdata,
                            tr[i].cs_n, tr[i].rd_n, tr[i].wr_n, tr[i].wait_exp,
                            tr[i].addr, tr[i].wdata, exp_rd));
            @(negedge clk);
        end
        m_read = 0; m_write = 0;
        #1;
        check(s_cs_n && s_rd_n && s_wr_n && !m_waitreq, "R1",
              $sformatf("idle after access actual cs%b rd%b wr%b wait%b expected 1 1 1 0",
                        s_cs_n, s_rd_n, s_wr_n, m_waitreq));
        @(negedge clk);
        if (wr) foreach (lanes[i]) ref_mem[base + 5'(lanes[i])] =
                    regm ? wd[7:0] : wd[8*lanes[i] +: 8];
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog expired (all requirements) actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) ref_mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        #1;
        check(s_cs_n && s_rd_n && s_wr_n && !m_waitreq && m_rdata == 0, "R1",
              $sformatf("reset state actual cs%b rd%b wr%b wait%b rd%h expected 1 1 1 0 0",
                        s_cs_n, s_rd_n, s_wr_n, m_waitreq, m_rdata));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 byte-lane read, ascending, little-endian
        run(0, 0, 7'h00, '0, 4'hF, 0, "R2 R6 R7");
        // R9 low address bits ignored in byte-lane mode
        run(0, 0, 7'h13, '0, 4'h0, 0, "R9 R2");
        // R3 sparse byte enables
        run(1, 0, 7'h08, 32'hA1B2C3D4, 4'b1010, 0, "R3 R6");
        run(0, 0, 7'h08, '0, 4'hF, 0, "R3 readback");
        // R3 no enables: no strobe, R7 two-cycle completion
        run(1, 0, 7'h0C, 32'hFFFFFFFF, 4'b0000, 0, "R3 R7 empty");
        run(0, 0, 7'h0C, '0, 4'hF, 0, "R3 empty readback");
        run(1, 0, 7'h14, 32'h5566_7788, 4'hF, 0, "R3 full");
        // R4 register read, zero-filled upper bits
        run(0, 1, 7'h08, '0, 4'hF, 0, "R4");
        // R5 register write ignores byte enables
        run(1, 1, 7'h7C, 32'hDEAD_BE5A, 4'b0000, 0, "R5");
        run(0, 1, 7'h7C, '0, 4'h0, 0, "R5 R4 readback");
        // R8 mode change during an access
        run(0, 0, 7'h14, '0, 4'hF, 1, "R8 byte-lane");
        run(0, 1, 7'h54, '0, 4'hF, 1, "R8 register");
        run(1, 1, 7'h18, 32'h0000_0042, 4'hF, 1, "R8 R5 write");
        run(0, 0, 7'h18, '0, 4'hF, 0, "R8 R2 readback");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule